// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of several numbered localities owns a shared security device at any moment. Each locality has its own access byte. A host writes that byte to ask for ownership, give it up, take it by force, or clear a sticky flag. Reading the byte returns a status view of that locality: whether it owns the device, whether it has a request outstanding, whether anyone else is waiting, and whether it lost ownership to a forced takeover.

Ownership changes in two ways. A polite request never pre-empts the current owner. It is only recorded, and the owner sees that someone is waiting. A forced takeover succeeds only from a locality numbered above the current owner. When the owner releases, the highest-numbered waiting locality takes over and its request is consumed.

The register port carries one write and one read address per cycle. The read data and the owner outputs are registered.

Top module: `loc_owner_arb`

## Requirements
- R1: After reset no locality owns the device (`owner_valid` low), and every in-range locality reads 0x81.
- R2: Every in-range locality's status byte always has bit 7 (register valid) and bit 0 (establishment) set. Bits 6 and 3 always read 0.
- R3: A write with bit 1 (request) set while nothing is owned makes the writer the owner at once. Its status then shows bit 5 (active), and `owner_loc` equals the writer.
- R4: A write with bit 1 set from a locality other than the current owner leaves ownership unchanged. It sets that locality's request flag, which reads back as bit 1.
- R5: A write with bit 3 (seize) from a locality numbered at or below the owner changes nothing: not ownership, not any flag.
- R6: A write with bit 3 from a locality numbered above the owner makes it the owner at once. The previous owner's bit 4 (been seized) becomes set and stays set.
- R7: A write with bit 4 set clears the writer's been-seized flag.
- R8: A write with bit 5 (release) from the owner gives up ownership. The highest-numbered locality with a request flag becomes the owner, and its flag is cleared. If no locality is waiting, the device is left unowned. Bit 5 from a non-owner has no effect.
- R9: Bit 2 (pending) of a locality reads 1 exactly when some other locality has its request flag set.
- R10: When one write carries several command bits, they take effect in this order: release, then seize, then request, then clear-been-seized.
- R11: A seize write while nothing is owned makes the writer the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the access byte of `wr_loc` |
| wr_loc | input | LOC_W | Locality that writes; out-of-range values are ignored |
| wr_data | input | 8 | Command bits: 5 release, 4 clear been-seized, 3 seize, 1 request |
| rd_loc | input | LOC_W | Locality whose status is read |
| rd_data | output | 8 | Registered status of `rd_loc` one cycle later (0 for out-of-range) |
| owner_valid | output | 1 | A locality currently owns the device |
| owner_loc | output | LOC_W | Current owner (0 when none) |

## Verification
Directed sequences cover the following cases:
- Requests made while the device is free, which tells immediate grant apart from queueing.
- Seizes from a lower locality, the same locality and a higher locality, which separates the ignored case from the taking case.
- Release with several waiting localities, which shows that the highest number wins rather than the first to ask.
- Multi-bit writes such as release-plus-request from the owner, which come out differently under any other order of evaluation.

Random writes of mixed command bytes from random localities then keep every status byte and both owner outputs in line with a bench model. This also covers out-of-order hand-overs and pending-bit corner cases.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  // access byte bit positions (behaviour depends on them)
  localparam int ACC_VALID  = 7;
  localparam int ACC_ACTIVE = 5;
  localparam int ACC_SEIZED = 4;
  localparam int ACC_SEIZE  = 3;
  localparam int ACC_PEND   = 2;
  localparam int ACC_REQ    = 1;
  localparam int ACC_EST    = 0;
  localparam int ACC_W      = 8;
  typedef logic [ACC_W-1:0] acc_byte_t;
endpackage

// File: rtl/loc_arb_next.sv
module loc_arb_next
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               wr_en,
  input  logic [LOC_W-1:0]   wr_loc,
  input  acc_byte_t          wr_data,
  input  logic               cur_valid,
  input  logic [LOC_W-1:0]   cur_owner,
  input  logic [NUM_LOC-1:0] cur_req,
  input  logic [NUM_LOC-1:0] cur_seized,
  output logic               nxt_valid,
  output logic [LOC_W-1:0]   nxt_owner,
  output logic [NUM_LOC-1:0] nxt_req,
  output logic [NUM_LOC-1:0] nxt_seized
);
  logic hit;
  logic unused_bits;
  assign unused_bits = ^{wr_data[7:6], wr_data[ACC_PEND], wr_data[ACC_EST]};
  assign hit = wr_en && (int'(wr_loc) < NUM_LOC);

  function automatic logic [LOC_W-1:0] top_req(input logic [NUM_LOC-1:0] r);
    logic [LOC_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NUM_LOC; i++) if (r[i]) idx = LOC_W'(i);
    return idx;
  endfunction

  always_comb begin
    nxt_valid  = cur_valid;
    nxt_owner  = cur_owner;
    nxt_req    = cur_req;
    nxt_seized = cur_seized;
    // 1: release by owner, hand over to highest waiter
    if (hit && wr_data[ACC_ACTIVE] && nxt_valid && nxt_owner == wr_loc) begin
      if (|nxt_req) begin
        nxt_owner          = top_req(nxt_req);
        nxt_req[nxt_owner] = 1'b0;
      end else begin
        nxt_valid = 1'b0;
        nxt_owner = '0;
      end
    end
    // 2: seize, only upward
    if (hit && wr_data[ACC_SEIZE]) begin
      if (!nxt_valid) begin
        nxt_valid       = 1'b1;
        nxt_owner       = wr_loc;
        nxt_req[wr_loc] = 1'b0;
      end else if (wr_loc > nxt_owner) begin
        nxt_seized[nxt_owner] = 1'b1;
        nxt_owner             = wr_loc;
        nxt_req[wr_loc]       = 1'b0;
      end
    end
    // 3: polite request
    if (hit && wr_data[ACC_REQ]) begin
      if (!nxt_valid) begin
        nxt_valid = 1'b1;
        nxt_owner = wr_loc;
      end else if (nxt_owner != wr_loc) begin
        nxt_req[wr_loc] = 1'b1;
      end
    end
    // 4: clear sticky seized flag
    if (hit && wr_data[ACC_SEIZED]) nxt_seized[wr_loc] = 1'b0;
  end
endmodule

// File: rtl/loc_arb_state.sv
module loc_arb_state #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nxt_valid,
  input  logic [LOC_W-1:0]   nxt_owner,
  input  logic [NUM_LOC-1:0] nxt_req,
  input  logic [NUM_LOC-1:0] nxt_seized,
  output logic               cur_valid,
  output logic [LOC_W-1:0]   cur_owner,
  output logic [NUM_LOC-1:0] cur_req,
  output logic [NUM_LOC-1:0] cur_seized
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_valid  <= 1'b0;
      cur_owner  <= '0;
      cur_req    <= '0;
      cur_seized <= '0;
    end else begin
      cur_valid  <= nxt_valid;
      cur_owner  <= nxt_owner;
      cur_req    <= nxt_req;
      cur_seized <= nxt_seized;
    end
  end

  // an owner never also holds a request flag
  assert_owner_no_req_R8: assert property (@(posedge clk) disable iff (rst)
    cur_valid |-> !cur_req[cur_owner]);
  // nothing waits while the device is free
  assert_free_no_waiters_R8: assert property (@(posedge clk) disable iff (rst)
    !cur_valid |-> (cur_req == '0));
endmodule

// File: rtl/loc_arb_status.sv
module loc_arb_status
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LOC_W-1:0]   rd_loc,
  input  logic               cur_valid,
  input  logic [LOC_W-1:0]   cur_owner,
  input  logic [NUM_LOC-1:0] cur_req,
  input  logic [NUM_LOC-1:0] cur_seized,
  output acc_byte_t          rd_data
);
  acc_byte_t stat [NUM_LOC];

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_stat
    logic [NUM_LOC-1:0] others;
    assign others = cur_req & ~(NUM_LOC'(1) << i);
    always_comb begin
      stat[i]             = '0;
      stat[i][ACC_VALID]  = 1'b1;
      stat[i][ACC_EST]    = 1'b1;
      stat[i][ACC_ACTIVE] = cur_valid && (int'(cur_owner) == i);
      stat[i][ACC_SEIZED] = cur_seized[i];
      stat[i][ACC_PEND]   = |others;
      stat[i][ACC_REQ]    = cur_req[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (int'(rd_loc) < NUM_LOC) rd_data <= stat[rd_loc];
    else rd_data <= '0;
  end

  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && int'($past(rd_loc)) < NUM_LOC) |->
      (rd_data[ACC_VALID] && rd_data[ACC_EST] && !rd_data[6] && !rd_data[ACC_SEIZE]));
endmodule

// File: rtl/loc_owner_arb.sv
module loc_owner_arb
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  localparam int LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LOC_W-1:0] wr_loc,
  input  logic [7:0]       wr_data,
  input  logic [LOC_W-1:0] rd_loc,
  output logic [7:0]       rd_data,
  output logic             owner_valid,
  output logic [LOC_W-1:0] owner_loc
);
  logic               nxt_valid, cur_valid;
  logic [LOC_W-1:0]   nxt_owner, cur_owner;
  logic [NUM_LOC-1:0] nxt_req, cur_req, nxt_seized, cur_seized;

  loc_arb_next #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_next (
    .wr_en(wr_en), .wr_loc(wr_loc), .wr_data(wr_data),
    .cur_valid(cur_valid), .cur_owner(cur_owner),
    .cur_req(cur_req), .cur_seized(cur_seized),
    .nxt_valid(nxt_valid), .nxt_owner(nxt_owner),
    .nxt_req(nxt_req), .nxt_seized(nxt_seized));

  loc_arb_state #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_state (
    .clk(clk), .rst(rst),
    .nxt_valid(nxt_valid), .nxt_owner(nxt_owner),
    .nxt_req(nxt_req), .nxt_seized(nxt_seized),
    .cur_valid(cur_valid), .cur_owner(cur_owner),
    .cur_req(cur_req), .cur_seized(cur_seized));

  loc_arb_status #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_status (
    .clk(clk), .rst(rst), .rd_loc(rd_loc),
    .cur_valid(cur_valid), .cur_owner(cur_owner),
    .cur_req(cur_req), .cur_seized(cur_seized),
    .rd_data(rd_data));

  assign owner_valid = cur_valid;
  assign owner_loc   = cur_owner;

  logic wr_ok;
  assign wr_ok = wr_en && (int'(wr_loc) < NUM_LOC);

  assert_free_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !cur_valid && (wr_data[ACC_REQ] || wr_data[ACC_SEIZE]))
      |=> (cur_valid && cur_owner == $past(wr_loc)));

  assert_seize_low_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && wr_data == 8'h08 && cur_valid && wr_loc <= cur_owner)
      |=> (cur_valid && $stable(cur_owner) && $stable(cur_req) && $stable(cur_seized)));

  assert_seize_marks_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && wr_data == 8'h08 && cur_valid && wr_loc > cur_owner)
      |=> (cur_seized[$past(cur_owner)] && cur_owner == $past(wr_loc)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(cur_valid) && $stable(cur_owner) && $stable(cur_req)));
endmodule

// File: tb/tb_loc_owner_arb.sv
module tb_loc_owner_arb;
  localparam int NL = 5;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [LW-1:0] wr_loc = '0;
  logic [7:0]    wr_data = '0;
  logic [LW-1:0] rd_loc = '0;
  logic [7:0]    rd_data;
  logic          owner_valid;
  logic [LW-1:0] owner_loc;

  always #4 clk = ~clk;

  loc_owner_arb #(.NUM_LOC(NL)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_loc(wr_loc), .wr_data(wr_data),
    .rd_loc(rd_loc), .rd_data(rd_data),
    .owner_valid(owner_valid), .owner_loc(owner_loc));

  int checks = 0, fails = 0;
  bit m_valid;
  int m_owner;
  bit m_req [NL];
  bit m_sz  [NL];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_stat(int i);
    logic [7:0] s;
    s = 8'h81;
    if (m_valid && m_owner == i) s |= 8'h20;
    if (m_sz[i]) s |= 8'h10;
    if (m_req[i]) s |= 8'h02;
    for (int j = 0; j < NL; j++) if (j != i && m_req[j]) s |= 8'h04;
    return s;
  endfunction

  function automatic void m_write(int l, logic [7:0] d);
    if (d[5] && m_valid && m_owner == l) begin
      int best;
      best = -1;
      for (int j = 0; j < NL; j++) if (m_req[j]) best = j;
      if (best >= 0) begin m_owner = best; m_req[best] = 0; end
      else begin m_valid = 0; m_owner = 0; end
    end
    if (d[3]) begin
      if (!m_valid) begin m_valid = 1; m_owner = l; m_req[l] = 0; end
      else if (l > m_owner) begin m_sz[m_owner] = 1; m_owner = l; m_req[l] = 0; end
    end
    if (d[1]) begin
      if (!m_valid) begin m_valid = 1; m_owner = l; end
      else if (m_owner != l) m_req[l] = 1;
    end
    if (d[4]) m_sz[l] = 0;
  endfunction

  task automatic do_write(int l, logic [7:0] d, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_loc = LW'(l); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_write(l, d);
    check({tag, " owner_valid"}, 32'(owner_valid), 32'(m_valid));
    check({tag, " owner_loc"}, 32'(owner_loc), 32'(m_owner));
  endtask

  task automatic do_read(int l, string tag);
    @(negedge clk);
    rd_loc = LW'(l);
    @(negedge clk);
    check(tag, 32'(rd_data), 32'(m_stat(l)));
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    m_valid = 0; m_owner = 0;
    for (int i = 0; i < NL; i++) begin m_req[i] = 0; m_sz[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 owner_valid", 32'(owner_valid), 32'd0);
    for (int i = 0; i < NL; i++) do_read(i, "R1 reset status");
    check("R1 status literal", 32'(m_stat(0)), 32'h81);
    // R3 grant when free
    do_write(1, 8'h02, "R3");
    do_read(1, "R3 owner status 0xA1");
    // R4 / R9 queueing and pending
    do_write(0, 8'h02, "R4");
    do_read(0, "R4 requester 0x83");
    do_read(1, "R9 owner sees pending 0xA5");
    do_write(3, 8'h02, "R4");
    do_read(0, "R9 pending from other 0x87");
    // R5 seize lower / equal ignored
    do_write(0, 8'h08, "R5 lower");
    do_write(1, 8'h08, "R5 equal");
    do_read(1, "R5 owner unchanged");
    do_read(0, "R5 flags unchanged");
    // R6 seize higher
    do_write(2, 8'h08, "R6");
    do_read(1, "R6 been-seized 0x95");
    do_read(2, "R6 new owner");
    // R7 clear
    do_write(1, 8'h10, "R7");
    do_read(1, "R7 cleared 0x85");
    // R8 release
    do_write(0, 8'h20, "R8 non-owner release");
    do_write(2, 8'h20, "R8 handover to highest");
    do_read(3, "R8 new owner req cleared");
    do_write(3, 8'h20, "R8 next handover");
    do_read(0, "R8 last waiter 0xA1");
    // R10 ordering
    do_write(4, 8'h2A, "R10 release+seize+request");
    do_read(0, "R10 seized owner");
    do_write(4, 8'h22, "R10 release then request");
    do_read(4, "R10 regrant");
    do_write(0, 8'h12, "R10 request then clear");
    do_read(0, "R10 status");
    // R11 seize when free
    do_write(4, 8'h20, "R11 prep");
    do_write(0, 8'h20, "R11 prep");
    do_write(2, 8'h08, "R11 seize free");
    do_read(2, "R11 status");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] d;
      int l;
      l = $urandom_range(NL - 1);
      if ($urandom_range(9) == 0) d = 8'($urandom);
      else begin
        d = 8'h00;
        if ($urandom_range(3) == 0) d[5] = 1'b1;
        if ($urandom_range(3) == 0) d[3] = 1'b1;
        if ($urandom_range(2) == 0) d[1] = 1'b1;
        if ($urandom_range(4) == 0) d[4] = 1'b1;
      end
      do_write(l, d, "R10 random");
      do_read($urandom_range(NL - 1), "R9 random status");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule